// File: doc/BRIEF.md
# Bidirectional Bus Transceiver with Parity Generator and Checker

This block moves an 8-bit word between two bus ports, A and B, in the direction chosen by a direction input, and can disconnect from both ports at once through an active-high disable input. Each port, and the shared parity pin, is modelled as a value output paired with a drive-enable output, alongside a separate sampled input. The surrounding tri-state pad logic can then resolve the bus, and a bench can detect two drivers on one net.

When the block transmits (A to B), it counts the ones on A and drives the parity pin. The bit it drives gives the nine-bit group (A plus parity) the sense chosen by the odd/even select. When the block receives (B to A), the parity pin becomes an input. The block then checks B together with the received parity bit against the same chosen sense, and pulls an active-low error flag down on a mismatch. The path is purely combinational and does not invert data.

Top module: `xfer_parity_xcvr`

## Requirements
- R1: With disable low and dir_i high (transmit), b_oe_o is 1, b_o equals a_i bit for bit, and a_oe_o is 0.
- R2: With disable low and dir_i low (receive), a_oe_o is 1, a_o equals b_i bit for bit, and b_oe_o is 0.
- R3: With dis_i high, a_oe_o, b_oe_o and par_oe_o are all 0, whatever the other inputs are.
- R4: par_oe_o is 1 only in transmit with disable low. It is 0 in receive and while disabled.
- R5: In transmit, par_o makes the count of ones in {a_i, par_o} odd when odd_i is 1 and even when odd_i is 0. For example, with odd_i 0 and five ones on a_i, par_o is 1.
- R6: In receive with disable low, err_no is 0 exactly when the count of ones in {b_i, par_i} disagrees with the sense chosen by odd_i (1 selects odd, 0 selects even). For example, with odd_i 1, par_i 1 and three ones on b_i, err_no is 0.
- R7: err_no is 1 in transmit and while disabled, for any b_i, par_i and odd_i.
- R8: Each value output (a_o, b_o, par_o) reads 0 whenever its drive-enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir_i | input | 1 | 1: A drives B (transmit); 0: B drives A (receive) |
| dis_i | input | 1 | 1: both ports and the parity pin undriven |
| odd_i | input | 1 | 1: odd parity sense; 0: even |
| a_i | input | 8 | Sampled A-port bus |
| a_o | output | 8 | Value driven onto the A port |
| a_oe_o | output | 1 | Drive-enable for the A port |
| b_i | input | 8 | Sampled B-port bus |
| b_o | output | 8 | Value driven onto the B port |
| b_oe_o | output | 1 | Drive-enable for the B port |
| par_i | input | 1 | Sampled parity pin (used in receive) |
| par_o | output | 1 | Parity value driven in transmit |
| par_oe_o | output | 1 | Drive-enable for the parity pin |
| err_no | output | 1 | Active-low parity error flag |

## Verification
Every result is combinational, so it is due in the same cycle as the stimulus that causes it, with no register on any path. The bench applies each input set just after a rising clock edge and samples one nanosecond later, still within the same cycle and well clear of the next edge. It then compares all outputs against values computed by bench functions from the ones count. The stimulus sweeps all 256 words in both directions, with both parity senses and both received parity bits. It then adds seeded random vectors that also toggle the disable input.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/xfer_parity.sv
module xfer_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] d_i,
  output logic         p_o
);
  logic [W:0] acc;

  assign acc[0] = 1'b0;
  for (genvar g = 0; g < W; g++) begin : g_chain
    assign acc[g+1] = acc[g] ^ d_i[g];
  end
  assign p_o = acc[W];
endmodule

// File: rtl/xfer_dir_ctl.sv
module xfer_dir_ctl
  import xfer_pkg::*;
(
  input  logic dir_i,
  input  logic dis_i,
  output logic tx_act_o,
  output logic rx_act_o
);
  xfer_dir_e dir;

  assign dir      = xfer_dir_e'(dir_i);
  assign tx_act_o = !dis_i && (dir == DIR_TX);
  assign rx_act_o = !dis_i && (dir == DIR_RX);
endmodule

// File: rtl/xfer_parity_xcvr.sv
module xfer_parity_xcvr #(
  parameter int W = 8
) (
  input  logic         dir_i,
  input  logic         dis_i,
  input  logic         odd_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o,
  input  logic         par_i,
  output logic         par_o,
  output logic         par_oe_o,
  output logic         err_no
);
  logic tx_act, rx_act;
  logic a_par, b_par;

  xfer_dir_ctl u_ctl (
    .dir_i   (dir_i),
    .dis_i   (dis_i),
    .tx_act_o(tx_act),
    .rx_act_o(rx_act)
  );

  xfer_parity #(.W(W)) u_par_a (.d_i(a_i), .p_o(a_par));
  xfer_parity #(.W(W)) u_par_b (.d_i(b_i), .p_o(b_par));

  assign b_oe_o   = tx_act;
  assign a_oe_o   = rx_act;
  assign par_oe_o = tx_act;

  // undriven value outputs held at 0
  assign b_o   = tx_act ? a_i : '0;
  assign a_o   = rx_act ? b_i : '0;
  assign par_o = tx_act & (a_par ^ odd_i);

  // nine-bit sum sense must equal odd_i
  assign err_no = !(rx_act && ((b_par ^ par_i) != odd_i));
endmodule

// File: rtl/xfer_parity_xcvr_chk.sv
module xfer_parity_xcvr_chk #(
  parameter int W = 8
) (
  input logic         dir_i,
  input logic         dis_i,
  input logic         odd_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] a_o,
  input logic         a_oe_o,
  input logic [W-1:0] b_i,
  input logic [W-1:0] b_o,
  input logic         b_oe_o,
  input logic         par_i,
  input logic         par_o,
  input logic         par_oe_o,
  input logic         err_no
);
  always_comb begin
    // R1
    tx_path_chk: assert (!(!dis_i && dir_i) || (b_oe_o && !a_oe_o && b_o == a_i));
    // R2
    rx_path_chk: assert (!(!dis_i && !dir_i) || (a_oe_o && !b_oe_o && a_o == b_i));
    // R3
    all_hiz_chk: assert (!dis_i || (!a_oe_o && !b_oe_o && !par_oe_o));
    // R3
    no_contention_chk: assert (!(a_oe_o && b_oe_o));
    // R4
    par_drive_chk: assert (par_oe_o == b_oe_o);
    // R5
    tx_parity_chk: assert (!par_oe_o || ((^{a_i, par_o}) == odd_i));
    // R6
    rx_err_chk: assert (!a_oe_o || (err_no == ((^{b_i, par_i}) == odd_i)));
    // R7
    err_idle_chk: assert (a_oe_o || err_no);
    // R8
    zero_when_off_chk: assert ((a_oe_o || a_o == '0) && (b_oe_o || b_o == '0)
                               && (par_oe_o || !par_o));
  end
endmodule

bind xfer_parity_xcvr xfer_parity_xcvr_chk #(.W(W)) chk_i (.*);

// File: tb/xfer_parity_xcvr_tb_top.sv
`timescale 1ns/1ps
module xfer_parity_xcvr_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic dir_i, dis_i, odd_i, par_i;
  logic [W-1:0] a_i, b_i;
  logic [W-1:0] a_o, b_o;
  logic a_oe_o, b_oe_o, par_o, par_oe_o, err_no;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  xfer_parity_xcvr #(.W(W)) dut_i (
    .dir_i(dir_i), .dis_i(dis_i), .odd_i(odd_i),
    .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe_o),
    .b_i(b_i), .b_o(b_o), .b_oe_o(b_oe_o),
    .par_i(par_i), .par_o(par_o), .par_oe_o(par_oe_o),
    .err_no(err_no)
  );

  function automatic logic exp_par(input logic [W-1:0] d, input logic odd);
    int n = $countones(d);
    // choose p so (n + p) mod 2 matches the sense
    return ((n % 2) == 1) ? !odd : odd;
  endfunction

  function automatic logic exp_err_n(input logic [W-1:0] d, input logic p,
                                     input logic odd, input logic dir, input logic dis);
    int n = $countones(d) + int'(p);
    if (dis || dir) return 1'b1;
    return ((n % 2) == 1) == odd;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h dir=%0b dis=%0b odd=%0b a=%0h b=%0h p=%0b",
               req, act, exp, dir_i, dis_i, odd_i, a_i, b_i, par_i);
    end
  endtask

  task automatic apply(input logic dir, input logic dis, input logic odd,
                       input logic [W-1:0] a, input logic [W-1:0] b, input logic p);
    logic tx, rx;
    @(posedge clk);
    dir_i = dir; dis_i = dis; odd_i = odd; a_i = a; b_i = b; par_i = p;
    #1;
    tx = !dis && dir;
    rx = !dis && !dir;
    chk("R1 b_oe", {31'd0, b_oe_o}, {31'd0, tx});
    chk("R2 a_oe", {31'd0, a_oe_o}, {31'd0, rx});
    chk("R4 par_oe", {31'd0, par_oe_o}, {31'd0, tx});
    if (tx) begin
      chk("R1 b_o", {24'd0, b_o}, {24'd0, a});
      chk("R5 par_o", {31'd0, par_o}, {31'd0, exp_par(a, odd)});
    end
    if (rx) chk("R2 a_o", {24'd0, a_o}, {24'd0, b});
    if (dis) chk("R3 hiz", {29'd0, a_oe_o, b_oe_o, par_oe_o}, 32'd0);
    if (rx) chk("R6 err_no", {31'd0, err_no}, {31'd0, exp_err_n(b, p, odd, dir, dis)});
    else    chk("R7 err_no", {31'd0, err_no}, 32'd1);
    if (!tx) chk("R8 b_o/par_o off", {23'd0, b_o, par_o}, 32'd0);
    if (!rx) chk("R8 a_o off", {24'd0, a_o}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    dir_i = 0; dis_i = 1; odd_i = 0; a_i = '0; b_i = '0; par_i = 0;
    repeat (3) @(posedge clk);
    #1;
    // reset/idle state: disabled
    chk("R3 idle hiz", {29'd0, a_oe_o, b_oe_o, par_oe_o}, 32'd0);
    chk("R7 idle err", {31'd0, err_no}, 32'd1);
    rst_ni = 1'b1;

    // directed examples
    apply(1'b1, 1'b0, 1'b0, 8'b0001_1111, 8'h00, 1'b0);
    chk("R5 even five ones", {31'd0, par_o}, 32'd1);
    apply(1'b0, 1'b0, 1'b1, 8'h00, 8'b0000_0111, 1'b1);
    chk("R6 odd p1 three ones", {31'd0, err_no}, 32'd0);
    apply(1'b0, 1'b1, 1'b1, 8'hFF, 8'h5A, 1'b1);
    apply(1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1);
    chk("R5 odd zero ones", {31'd0, par_o}, 32'd1);

    // full sweep, both directions, both senses, both parity inputs
    for (int v = 0; v < 256; v++) begin
      for (int m = 0; m < 4; m++) begin
        apply(1'b1, 1'b0, m[0], v[7:0], ~v[7:0], m[1]);
        apply(1'b0, 1'b0, m[0], ~v[7:0], v[7:0], m[1]);
      end
    end

    // seeded random, including disable
    for (int i = 0; i < 2000; i++) begin
      logic [5:0] r;
      r = 6'($urandom);
      apply(r[0], r[1] & r[2], r[3], 8'($urandom), 8'($urandom), r[4]);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule